// File: doc/BRIEF.md
# Clock Source Selector and Prescalers

This unit picks one base timing source out of three and derives three clock-enable streams from it, one each for the core, the peripheral domain and the external bus. The design runs on one fast system clock. Each source arrives as a one-cycle tick input: the main oscillator, the PLL output and the sub oscillator. The main oscillator is halved before use. Each tree has its own 4-bit ratio, and each tree output is a single-cycle enable pulse that downstream logic uses to qualify its flops.

Software drives the unit through a plain register port with three registers: a control register (source code, PLL enable, sub oscillator enable, sticky error) and two ratio registers. A request to run from the PLL is refused unless the PLL is enabled and reports lock. A ratio update waits for the running division period to finish. Any change of the selected source re-aligns all three trees.

Top module: `clkgen_top`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the first ratio register (address 1) reads 0x03 and the second ratio register (address 2) reads 0x00. The pll_on, sub_on and src_err outputs are low.
- R2: Control bits 1:0 equal to 00 or 01 select the main tick halved, so with main ticks every 2 cycles a ratio value v gives an enable period of 4*(v+1) cycles.
- R3: Control bits 1:0 equal to 10 select the PLL tick, giving an enable period of (v+1) PLL ticks.
- R4: Control bits 1:0 equal to 11 select the sub tick, giving an enable period of (v+1) sub ticks.
- R5: A ratio field value v divides the base by v+1. The core ratio is bits 7:4 and the peripheral ratio is bits 3:0 of address 1. The external bus ratio is bits 7:4 of address 2. Each tree follows only its own field.
- R6: Bits 3:0 of address 2 are not stored and read as 0.
- R7: A control write that selects 10 while the written PLL enable bit (bit 2) is 0, or while pll_locked is low, keeps the previous source code. The other written bits still take effect, and the error flag (control bit 4, output src_err) sets and stays set until reset.
- R8: A new ratio applies only after the prescaler's current terminal count, so the period in progress when the write lands keeps the old length.
- R9: A change of the selected source restarts all three prescalers. With the PLL ticking every cycle and ratio v, the first enable pulse after the accepting write edge appears v+1 edges later. Switching between codes 00 and 01 is not a change of source.
- R10: Output pll_on follows control bit 2 and output sub_on follows control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_tick | input | 1 | One-cycle pulse per main oscillator period |
| pll_tick | input | 1 | One-cycle pulse per PLL output period |
| sub_tick | input | 1 | One-cycle pulse per sub oscillator period |
| pll_locked | input | 1 | PLL lock indication |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 ratios core/peripheral, 2 external bus ratio) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| core_en | output | 1 | Core tree enable pulse |
| per_en | output | 1 | Peripheral tree enable pulse |
| ext_en | output | 1 | External bus tree enable pulse |
| pll_on | output | 1 | PLL enable request |
| sub_on | output | 1 | Sub oscillator enable request |
| src_err | output | 1 | Sticky refused-PLL-selection flag |

## Verification
The bench targets the refused PLL selection in both of its forms, enable clear and lock low. A design that accepted either request would read back source 10 and run the trees at PLL speed. A ratio write placed right after a pulse must leave that period at its old length; a design that loaded the ratio at once would cut the period short. The bench switches from the main source to the PLL and counts edges to the first pulse, which catches a design that fails to restart the counters and so lands the pulse at a random point. It also checks that code 01 behaves like 00 and that the low nibble of the external ratio register reads zero.

// File: rtl/clkgen_pkg.sv
// Shared types and constants for the clock source selector.
// Assumes an 8-bit register port with 4-bit ratio fields.
package clkgen_pkg;
    localparam int DW      = 8;
    localparam int AW      = 2;
    localparam int RATIO_W = 4;
    localparam int NTREE   = 3;

    typedef enum logic [1:0] {SEL_MAIN, SEL_PLL, SEL_SUB} sel_t;

    localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [AW-1:0] ADDR_DIV0 = 2'd1;
    localparam logic [AW-1:0] ADDR_DIV1 = 2'd2;

    localparam logic [1:0] SRC_PLL = 2'b10;
    localparam logic [1:0] SRC_SUB = 2'b11;

    // Map the 2-bit source code to a selection; 00 and 01 alias.
    function automatic sel_t decode_src(input logic [1:0] code);
        if (code == SRC_PLL)      return SEL_PLL;
        else if (code == SRC_SUB) return SEL_SUB;
        else                      return SEL_MAIN;
    endfunction
endpackage

// File: rtl/clkgen_regs.sv
// Register file: control and two ratio registers, PLL guard, restart pulse.
// Assumes single-cycle writes; reads are combinational.
module clkgen_regs
    import clkgen_pkg::*;
#(
    parameter logic [RATIO_W-1:0] CORE_RST = 4'd0,
    parameter logic [RATIO_W-1:0] PER_RST  = 4'd3,
    parameter logic [RATIO_W-1:0] EXT_RST  = 4'd0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [AW-1:0]      rd_addr,
    input  logic               pll_locked,
    output logic [DW-1:0]      rd_data,
    output sel_t               sel,
    output logic               pll_en,
    output logic               sub_en,
    output logic               err,
    output logic               restart,
    output logic [RATIO_W-1:0] ratio_core,
    output logic [RATIO_W-1:0] ratio_per,
    output logic [RATIO_W-1:0] ratio_ext
);
    logic [1:0] src_q;
    logic       ctrl_wr;
    logic       refuse;
    logic [1:0] src_next;

    // Decide the source code a control write would leave behind.
    always_comb begin
        ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
        refuse   = ctrl_wr && (wr_data[1:0] == SRC_PLL) && !(wr_data[2] && pll_locked);
        src_next = (ctrl_wr && !refuse) ? wr_data[1:0] : src_q;
        restart  = decode_src(src_next) != decode_src(src_q);
    end

    // Register state updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q      <= 2'b00;
            pll_en     <= 1'b0;
            sub_en     <= 1'b0;
            err        <= 1'b0;
            ratio_core <= CORE_RST;
            ratio_per  <= PER_RST;
            ratio_ext  <= EXT_RST;
        end else begin
            src_q <= src_next;
            if (refuse) err <= 1'b1;
            if (ctrl_wr) begin
                pll_en <= wr_data[2];
                sub_en <= wr_data[3];
            end
            if (wr_en && wr_addr == ADDR_DIV0) begin
                ratio_core <= wr_data[7:4];
                ratio_per  <= wr_data[3:0];
            end
            if (wr_en && wr_addr == ADDR_DIV1) ratio_ext <= wr_data[7:4];
        end
    end

    assign sel = decode_src(src_q);

    // Read multiplexer.
    always_comb begin
        case (rd_addr)
            ADDR_CTRL: rd_data = {3'b000, err, sub_en, pll_en, src_q};
            ADDR_DIV0: rd_data = {ratio_core, ratio_per};
            ADDR_DIV1: rd_data = {ratio_ext, 4'b0000};
            default:   rd_data = '0;
        endcase
    end

    // PLL may only become the source if enabled and locked at the write.
    assert_pll_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == SRC_PLL && $past(src_q) != SRC_PLL) |-> ($past(pll_locked) && pll_en));

    // Error flag is sticky.
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/clkgen_base_sel.sv
// Base tick selection: halves the main tick and muxes in PLL or sub tick.
// Assumes ticks are single-cycle pulses in the system clock domain.
module clkgen_base_sel
    import clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sel_t sel,
    input  logic restart,
    input  logic main_tick,
    input  logic pll_tick,
    input  logic sub_tick,
    output logic base_tick
);
    logic phase_q;

    // Divide-by-two phase of the main tick, re-aligned on source change.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) phase_q <= 1'b0;
        else if (main_tick)    phase_q <= ~phase_q;
    end

    // Select the active base tick.
    always_comb begin
        case (sel)
            SEL_PLL: base_tick = pll_tick;
            SEL_SUB: base_tick = sub_tick;
            default: base_tick = main_tick && phase_q;
        endcase
    end

    // Halved main base never ticks on two cycles in a row.
    assert_main_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_MAIN && base_tick) |=> (!base_tick || sel != SEL_MAIN));
endmodule

// File: rtl/clkgen_prescaler.sv
// One programmable prescaler: emits a pulse every (ratio+1) base ticks.
// Ratio is sampled only at terminal count or restart.
module clkgen_prescaler #(
    parameter int                 RW        = 4,
    parameter logic [RW-1:0]      RST_RATIO = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_tick,
    input  logic          restart,
    input  logic [RW-1:0] ratio_in,
    output logic          en
);
    logic [RW-1:0] cnt_q;
    logic [RW-1:0] ratio_act_q;

    // Count base ticks, reload ratio at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            ratio_act_q <= RST_RATIO;
            en          <= 1'b0;
        end else if (restart) begin
            cnt_q       <= '0;
            ratio_act_q <= ratio_in;
            en          <= 1'b0;
        end else if (base_tick) begin
            if (cnt_q == ratio_act_q) begin
                cnt_q       <= '0;
                ratio_act_q <= ratio_in;
                en          <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                en    <= 1'b0;
            end
        end else begin
            en <= 1'b0;
        end
    end

    assert_en_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> $past(base_tick));

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= ratio_act_q);

    assert_ratio_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(base_tick) && !$past(restart)) |-> $stable(ratio_act_q));
endmodule

// File: rtl/clkgen_top.sv
// Clock source selector with three prescaled enable trees.
// Assumes all source ticks are synchronous single-cycle pulses.
module clkgen_top
    import clkgen_pkg::*;
#(
    parameter logic [RATIO_W-1:0] CORE_RST = 4'd0,
    parameter logic [RATIO_W-1:0] PER_RST  = 4'd3,
    parameter logic [RATIO_W-1:0] EXT_RST  = 4'd0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          main_tick,
    input  logic          pll_tick,
    input  logic          sub_tick,
    input  logic          pll_locked,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [1:0]    rd_addr,
    output logic [7:0]    rd_data,
    output logic          core_en,
    output logic          per_en,
    output logic          ext_en,
    output logic          pll_on,
    output logic          sub_on,
    output logic          src_err
);
    localparam logic [NTREE*RATIO_W-1:0] RST_PACK = {EXT_RST, PER_RST, CORE_RST};

    sel_t                     sel;
    logic                     restart;
    logic                     base_tick;
    logic [NTREE*RATIO_W-1:0] ratio_pack;
    logic [NTREE-1:0]         tree_en;

    clkgen_regs #(.CORE_RST(CORE_RST), .PER_RST(PER_RST), .EXT_RST(EXT_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .pll_locked(pll_locked), .rd_data(rd_data), .sel(sel),
        .pll_en(pll_on), .sub_en(sub_on), .err(src_err), .restart(restart),
        .ratio_core(ratio_pack[0*RATIO_W +: RATIO_W]),
        .ratio_per (ratio_pack[1*RATIO_W +: RATIO_W]),
        .ratio_ext (ratio_pack[2*RATIO_W +: RATIO_W])
    );

    clkgen_base_sel u_base (
        .clk(clk), .rst_n(rst_n), .sel(sel), .restart(restart),
        .main_tick(main_tick), .pll_tick(pll_tick), .sub_tick(sub_tick),
        .base_tick(base_tick)
    );

    for (genvar g = 0; g < NTREE; g++) begin : g_tree
        clkgen_prescaler #(.RW(RATIO_W), .RST_RATIO(RST_PACK[g*RATIO_W +: RATIO_W])) u_psc (
            .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .restart(restart),
            .ratio_in(ratio_pack[g*RATIO_W +: RATIO_W]), .en(tree_en[g])
        );
    end

    assign core_en = tree_en[0];
    assign per_en  = tree_en[1];
    assign ext_en  = tree_en[2];
endmodule

// File: tb/clkgen_top_bench.sv
module clkgen_top_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic main_tick = 1'b0;
    logic pll_tick = 1'b1;
    logic sub_tick;
    logic pll_locked = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic core_en, per_en, ext_en, pll_on, sub_on, src_err;
    logic [2:0] sub_cnt = '0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    typedef struct { int tree; int period; string tag; } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    // Source tick generators: main every 2 cycles, sub every 8, PLL every cycle.
    always @(posedge clk) begin
        main_tick <= ~main_tick;
        sub_cnt   <= sub_cnt + 3'd1;
    end
    assign sub_tick = (sub_cnt == 3'd7);

    clkgen_top u_clkgen_top (
        .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .pll_tick(pll_tick),
        .sub_tick(sub_tick), .pll_locked(pll_locked), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .core_en(core_en),
        .per_en(per_en), .ext_en(ext_en), .pll_on(pll_on), .sub_on(sub_on), .src_err(src_err)
    );

    function automatic logic tree_en(input int t);
        return (t == 0) ? core_en : (t == 1) ? per_en : ext_en;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Write starting at the current negedge.
    task automatic wr_now(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_now(a, d);
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(tag, int'(rd_data), exp);
    endtask

    // Driver: queue an expected period and wait until the monitor consumed it.
    task automatic expect_period(input int t, input int p, input string tag);
        exp_t e;
        e.tree = t; e.period = p; e.tag = tag;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
    endtask

    // Monitor: measure the second full interval between enable pulses.
    initial begin
        forever begin
            exp_t e;
            int n;
            wait (sb_q.size() > 0);
            e = sb_q[0];
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                while (!tree_en(e.tree)) @(negedge clk);
            end
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!tree_en(e.tree));
            chk(e.tag, n, e.period);
            void'(sb_q.pop_front());
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 ctrl", 2'd0, 8'h00);
        rd_chk("R1 div0", 2'd1, 8'h03);
        rd_chk("R1 div1", 2'd2, 8'h00);
        chk("R1 pll_on", int'(pll_on), 0);
        chk("R1 sub_on", int'(sub_on), 0);
        chk("R1 src_err", int'(src_err), 0);

        // R2 main/2 default
        expect_period(0, 4, "R2 core main r0");
        expect_period(1, 16, "R2 per main r3");
        expect_period(2, 4, "R2 ext main r0");

        // R5 and R6 ratio fields
        wr(2'd1, 8'h25);
        wr(2'd2, 8'hF7);
        rd_chk("R6 div1 low nibble", 2'd2, 8'hF0);
        rd_chk("R5 div0 readback", 2'd1, 8'h25);
        expect_period(0, 12, "R5 core r2");
        expect_period(1, 24, "R5 per r5");
        expect_period(2, 64, "R5 ext r15");

        // R2 alias code 01
        wr(2'd0, 8'h01);
        rd_chk("R2 ctrl 01", 2'd0, 8'h01);
        expect_period(0, 12, "R2 core code01");

        // R7 refused: lock low
        wr(2'd0, 8'h06);
        rd_chk("R7 lock low kept", 2'd0, 8'h15);
        chk("R7 src_err", int'(src_err), 1);
        chk("R10 pll_on", int'(pll_on), 1);
        expect_period(0, 12, "R7 core unchanged");

        // R7 refused: enable clear
        pll_locked = 1'b1;
        wr(2'd0, 8'h02);
        rd_chk("R7 enable clear kept", 2'd0, 8'h11);
        chk("R10 pll_on low", int'(pll_on), 0);

        // R3 PLL accepted
        wr(2'd0, 8'h06);
        rd_chk("R3 ctrl pll", 2'd0, 8'h16);
        chk("R7 err sticky", int'(src_err), 1);
        expect_period(0, 3, "R3 core pll r2");
        expect_period(1, 6, "R3 per pll r5");
        expect_period(2, 16, "R3 ext pll r15");

        // R4 sub source
        wr(2'd0, 8'h0F);
        rd_chk("R4 ctrl sub", 2'd0, 8'h1F);
        chk("R10 sub_on", int'(sub_on), 1);
        expect_period(0, 24, "R4 core sub r2");

        // R8 deferred ratio change
        wr(2'd0, 8'h06);
        wr(2'd1, 8'h75);
        expect_period(0, 8, "R8 core r7");
        @(negedge clk);
        while (!core_en) @(negedge clk);
        wr_now(2'd1, 8'h15);
        n = 1;
        while (!core_en) begin @(negedge clk); n++; end
        chk("R8 period in progress", n, 8);
        expect_period(0, 2, "R8 core new r1");

        // R9 restart on source change
        wr(2'd1, 8'h35);
        wr(2'd0, 8'h04);
        repeat (3) @(negedge clk);
        wr_now(2'd0, 8'h06);
        n = 0;
        while (!core_en) begin @(negedge clk); n++; end
        chk("R9 core first pulse", n, 4);
        wr(2'd0, 8'h04);
        repeat (5) @(negedge clk);
        wr_now(2'd0, 8'h06);
        n = 0;
        while (!per_en) begin @(negedge clk); n++; end
        chk("R9 per first pulse", n, 6);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule